// File: doc/BRIEF.md
# Presettable Decade/Binary Synchronous Counter

A 4-bit synchronous counter. A parameter selects one of two counting ranges. In decade mode it counts 0 to 9 and wraps. In binary mode it counts 0 to 15 and wraps. A second parameter selects how the active-low clear acts: it either zeroes the counter on the next rising clock edge, or forces zero at once without waiting for the clock.

An active-low load copies a 4-bit value into the counter on the rising edge. The counter advances only when two active-high enables are both high: a parallel enable and a trickle enable. The terminal-count flag is decoded from the current state and the trickle enable alone. A chain of counters can therefore be built by feeding each stage's flag into the next stage's trickle enable while one shared signal drives every parallel enable.

In decade mode, a loaded value from 10 to 15 is never flagged as terminal. It steps back into the 0 to 9 cycle within two counting clocks.

Top module: `syncnt4`

## Requirements
- R1: Apart from the asynchronous clear, the state changes only on a rising clock edge. Changing the load or data inputs between edges leaves the state unchanged.
- R2: With DECADE set or clear and ASYNC_CLR=0, clr_n low at a rising edge sets the state to 0000. This takes precedence over load and both enables.
- R3: With ASYNC_CLR=1, clr_n going low sets the state to 0000 at once, without a clock edge.
- R4: With clr_n high and ld_n low, the state takes din on the rising edge, whatever the values of en_p and en_t.
- R5: With clr_n, ld_n, en_p and en_t all high, the state increases by one on each rising edge.
- R6: With clr_n and ld_n high, if en_p or en_t is low the state is held.
- R7: The state wraps to 0 after 9 (1001) in decade mode (DECADE=1) and after 15 (1111) in binary mode (DECADE=0).
- R8: tc is high exactly when en_t is high and the state equals the maximum (9 in decade mode, 15 in binary mode). tc is combinational and does not depend on en_p.
- R9: In decade mode, counting from an illegal state follows these successors: 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2. The state is therefore back in 0 to 9 within two counting clocks, and tc stays low in states 10 to 15.
- R10: Two decade stages connected with the low stage's tc driving the high stage's en_t count 00 to 99 and wrap to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; synchronous or asynchronous depending on ASYNC_CLR |
| ld_n | input | 1 | Active-low parallel load |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates tc |
| din | input | 4 | Value to load |
| q | output | 4 | Counter state |
| tc | output | 1 | Terminal-count flag |

## Verification
Every one of the 16 load values is applied in each mode, and each load is followed by a mix of enable patterns. This separates the decade and binary successor rules, including the illegal-state successor table, and shows that a single low enable holds the state. The inputs drive a synchronous-clear decade instance and an asynchronous-clear binary instance in parallel. A clear pulse between edges therefore shows the two clear styles apart, and changing load and data between edges shows that nothing else changes the state outside an edge. A two-stage cascade run through more than a hundred counts confirms that tc carries correctly into the tens digit.

// File: rtl/syncnt4.sv
`timescale 1ns/1ps
module syncnt4 #(
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       ld_n,
  input  logic       en_p,
  input  logic       en_t,
  input  logic [3:0] din,
  output logic [3:0] q,
  output logic       tc
);
  localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

  function automatic logic [3:0] succ(input logic [3:0] s);
    if (DECADE && s > 4'd9) begin
      case (s)
        4'd10:   succ = 4'd11;
        4'd11:   succ = 4'd6;
        4'd12:   succ = 4'd13;
        4'd13:   succ = 4'd4;
        4'd14:   succ = 4'd15;
        default: succ = 4'd2;
      endcase
    end else begin
      succ = (s == TOP) ? 4'd0 : s + 4'd1;
    end
  endfunction

  logic       run;
  logic [3:0] d;

  assign run = ld_n & en_p & en_t;
  assign d   = !ld_n ? din : (run ? succ(q) : q);
  assign tc  = en_t && (q == TOP);

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) q <= 4'd0;
        else        q <= d;

      assert_aclr_R3: assert property (@(posedge clk) !clr_n |-> q == 4'd0);
    end else begin : g_sclr
      always_ff @(posedge clk)
        q <= clr_n ? d : 4'd0;

      assert_sclr_R2: assert property (@(posedge clk) !clr_n |=> q == 4'd0);
    end
  endgenerate

  assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(din));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(q));
  assert_inc_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (run && q < TOP) |=> q == $past(q) + 4'd1);
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (tc && en_p && ld_n) |=> q == 4'd0);

  generate
    if (DECADE) begin : g_dec_chk
      assert_recover_R9: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(run) && run && $past(q) > 4'd9) |=> q <= 4'd9);
      assert_no_tc_illegal_R9: assert property (@(posedge clk) disable iff (!clr_n)
        (q > 4'd9) |-> !tc);
    end
  endgenerate
endmodule

// File: tb/sim_syncnt4.sv
`timescale 1ns/1ps
module sim_syncnt4;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       clr_n = 1'b0, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q0, q1;
  logic       tc0, tc1;

  logic       c_clr_n = 1'b0;
  logic [3:0] qlo, qhi;
  logic       tclo, tchi;

  int checks = 0, failures = 0;
  int m0 = 0, m1 = 0;

  syncnt4 #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u0 (.clk(clk), .clr_n(clr_n), .ld_n(ld_n),
    .en_p(en_p), .en_t(en_t), .din(din), .q(q0), .tc(tc0));
  syncnt4 #(.DECADE(1'b0), .ASYNC_CLR(1'b1)) u1 (.clk(clk), .clr_n(clr_n), .ld_n(ld_n),
    .en_p(en_p), .en_t(en_t), .din(din), .q(q1), .tc(tc1));
  syncnt4 #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_lo (.clk(clk), .clr_n(c_clr_n), .ld_n(1'b1),
    .en_p(1'b1), .en_t(1'b1), .din(4'd0), .q(qlo), .tc(tclo));
  syncnt4 #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_hi (.clk(clk), .clr_n(c_clr_n), .ld_n(1'b1),
    .en_p(1'b1), .en_t(tclo), .din(4'd0), .q(qhi), .tc(tchi));

  function automatic int mnext(bit dec, int s);
    if (dec && s > 9) begin
      case (s)
        10: return 11; 11: return 6; 12: return 13;
        13: return 4;  14: return 15; default: return 2;
      endcase
    end
    return (s == (dec ? 9 : 15)) ? 0 : s + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit c, bit l, bit p, bit t, int d);
    string tag;
    clr_n = c; ld_n = l; en_p = p; en_t = t; din = 4'(d);
    if (!c) begin m0 = 0; m1 = 0; tag = "R2"; end
    else if (!l) begin m0 = d; m1 = d; tag = "R4"; end
    else if (p && t) begin m0 = mnext(1'b1, m0); m1 = mnext(1'b0, m1); tag = "R5/R7/R9"; end
    else tag = "R6";
    @(posedge clk); #1;
    chk({tag, " dec"}, int'(q0), m0);
    chk({tag, " bin"}, int'(q1), m1);
    chk("R8 dec tc", int'(tc0), int'(t && m0 == 9));
    chk("R8 bin tc", int'(tc1), int'(t && m1 == 15));
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(1'b0, 1'b1, 1'b1, 1'b1, 0);
    chk("R2 reset dec", int'(q0), 0);
    chk("R3 reset bin", int'(q1), 0);

    for (int v = 0; v < 16; v++) begin
      step(1'b1, 1'b0, v[0], v[1], v);
      for (int k = 0; k < 6; k++)
        step(1'b1, 1'b1, (k % 3) != 1, (k % 4) != 2, 0);
    end

    for (int v = 10; v < 16; v++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, v);
      chk("R9 tc low in illegal state", int'(tc0), 0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 0);
      chk("R9 back in range", int'(q0 <= 4'd9), 1);
    end

    step(1'b1, 1'b0, 1'b1, 1'b1, 9);
    en_t = 1'b1; en_p = 1'b0; #1;
    chk("R8 tc ignores en_p", int'(tc0), 1);
    en_t = 1'b0; #1;
    chk("R8 tc gated by en_t", int'(tc0), 0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 0);
    chk("R7 dec wrap", int'(q0), 0);

    step(1'b0, 1'b0, 1'b1, 1'b1, 7);
    chk("R2 clear beats load", int'(q0), 0);

    step(1'b1, 1'b0, 1'b0, 1'b0, 5);
    #2 ld_n = 1'b0; din = 4'd12; #2;
    chk("R1 no change between edges dec", int'(q0), 5);
    chk("R1 no change between edges bin", int'(q1), 5);
    step(1'b1, 1'b0, 1'b0, 1'b0, 12);

    #2 clr_n = 1'b0; #1;
    chk("R3 async clear immediate", int'(q1), 0);
    chk("R1 sync clear waits for edge", int'(q0), 12);
    @(posedge clk); #1;
    chk("R2 sync clear at edge", int'(q0), 0);
    m0 = 0; m1 = 0;
    step(1'b1, 1'b1, 1'b1, 1'b1, 0);

    c_clr_n = 1'b0;
    @(posedge clk); #1;
    c_clr_n = 1'b1;
    for (int i = 1; i <= 120; i++) begin
      @(posedge clk); #1;
      chk("R10 cascade", int'(qhi) * 10 + int'(qlo), i % 100);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule